// File: doc/BRIEF.md
# Character Page Memory Controller

This block owns the single-port memory that holds one complete text page (31 rows of 80 sixteen-bit character words). A host port fills the page and can read any word back for diagnostics. A refill engine empties the page one row at a time into a downstream line buffer. Each line-start pulse from the display side starts a burst that reads the 80 words of the current row on consecutive cycles. Each word goes out with a one-cycle load strobe. A page-start pulse puts the refill counters back on row 0, column 0.

The host and the refill engine share the memory port. The refill engine always has priority. The host sees `host_ready` drop in every cycle the refill engine reads, and holds its request until `host_ready` is high. The memory's write-enable and output-enable levels are brought out so that the board-level strobe behaviour can be observed.

Top module: `cfb_ctrl`

## Requirements
- R1: A host request is accepted at a rising edge where `host_req` and `host_ready` are both high. An accepted write with address below 2480 stores `host_wdata`. An accepted read raises `host_rvalid` for one cycle, one cycle after acceptance, with the stored word on `host_rdata`.
- R2: An accepted write whose address is 2480 or higher changes no stored word. An accepted read whose address is 2480 or higher returns `host_rdata` = 0 with `host_rvalid` high.
- R3: A `line_start` pulse while the refill engine is idle, not exhausted, and not receiving `page_start` produces exactly 80 `lb_load` pulses on consecutive cycles. The first pulse comes one cycle after the `line_start` cycle. Pulse c (0..79) carries the word at address row*80+c on `lb_data`.
- R4: Successive transfers take rows 0, 1, ..., 30 in order. After row 30 the row counter returns to 0, and any further `line_start` produces no load until a `page_start` pulse arrives. The next transfer after that pulse is row 0.
- R5: `page_start` takes precedence over everything in its cycle. No refill read happens in that cycle, so no `lb_load` follows it. An ongoing transfer is abandoned, and the next transfer begins at row 0, column 0.
- R6: `host_ready` is low in every cycle the refill engine reads the memory, including the `line_start` cycle that begins a transfer. A waiting host request is accepted in the first cycle after the transfer.
- R7: A `line_start` arriving while a transfer is in progress is ignored. The transfer continues unchanged and the row advances only once.
- R8: `mem_we` is high exactly in cycles that accept an in-range host write. `mem_oe` is high in those cycles and in refill read cycles, and low otherwise (host reads and idle cycles included).
- R9: After reset, `lb_load`, `host_rvalid`, `mem_we` and `mem_oe` are low, and `host_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host access request, held until accepted |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 12 | Host word address |
| host_wdata | input | 16 | Host write data |
| host_ready | output | 1 | Host request can be accepted this cycle |
| host_rvalid | output | 1 | Read data valid |
| host_rdata | output | 16 | Read data (zero for out-of-range addresses) |
| page_start | input | 1 | New-page pulse from the display side |
| line_start | input | 1 | New-line pulse from the display side |
| lb_load | output | 1 | Load strobe for the line buffer |
| lb_data | output | 16 | Word for the line buffer, valid with `lb_load` |
| mem_we | output | 1 | Memory write-enable level |
| mem_oe | output | 1 | Memory output-enable level |

## Verification
The results fall into two timing classes:

- **Combinational results.** `host_ready`, `mem_we` and `mem_oe` follow the inputs of the same cycle. The bench samples them shortly after driving inputs on the falling edge.
- **Registered results.** `host_rvalid` with `host_rdata`, and each `lb_load` with `lb_data`, appear one register stage after the rising edge that performs the access. For a row started in cycle k, the bench expects column c in cycle k+1+c and nothing in cycle k+81. For a read accepted at edge e, it expects the data at the first falling edge after e.

A host write raised in the same cycle as a `line_start` is expected to wait exactly 80 cycles.

// File: rtl/cfb_pkg.sv
package cfb_pkg;
  localparam int CFB_DW   = 16;
  localparam int CFB_AW   = 12;
  localparam int CFB_COLS = 80;
  localparam int CFB_ROWS = 31;

  typedef struct packed {
    logic              en;
    logic              we;
    logic [CFB_AW-1:0] addr;
    logic [CFB_DW-1:0] wdata;
  } cfb_mem_req_t;
endpackage

// File: rtl/cfb_mem.sv
module cfb_mem #(
  parameter int DW    = 16,
  parameter int AW    = 12,
  parameter int DEPTH = 2480
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  logic [DW-1:0] arr [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) arr[addr] <= wdata;
      else    q         <= arr[addr];
    end
  end
endmodule

// File: rtl/cfb_refill.sv
module cfb_refill #(
  parameter int AW   = 12,
  parameter int COLS = 80,
  parameter int ROWS = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          page_start,
  input  logic          line_start,
  output logic          fire,
  output logic [AW-1:0] rd_addr,
  output logic          load
);
  localparam int CW = $clog2(COLS);
  localparam int RW = $clog2(ROWS);

  logic          active_q, active_d;
  logic          done_q, done_d;
  logic [CW-1:0] col_q, col_d;
  logic [RW-1:0] row_q, row_d;
  logic [AW-1:0] base_q, base_d;
  logic          start_now;

  assign start_now = line_start && !active_q && !done_q && !page_start;
  assign fire      = (active_q && !page_start) || start_now;
  assign rd_addr   = base_q + AW'(col_q);

  always_comb begin
    active_d = active_q;
    done_d   = done_q;
    col_d    = col_q;
    row_d    = row_q;
    base_d   = base_q;
    if (page_start) begin
      active_d = 1'b0;
      done_d   = 1'b0;
      col_d    = '0;
      row_d    = '0;
      base_d   = '0;
    end else if (fire) begin
      if (col_q == CW'(COLS - 1)) begin
        col_d    = '0;
        active_d = 1'b0;
        if (row_q == RW'(ROWS - 1)) begin
          row_d  = '0;
          base_d = '0;
          done_d = 1'b1;
        end else begin
          row_d  = row_q + 1'b1;
          base_d = base_q + AW'(COLS);
        end
      end else begin
        col_d    = col_q + 1'b1;
        active_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      col_q    <= '0;
      row_q    <= '0;
      base_q   <= '0;
      load     <= 1'b0;
    end else begin
      active_q <= active_d;
      done_q   <= done_d;
      col_q    <= col_d;
      row_q    <= row_d;
      base_q   <= base_d;
      load     <= fire;
    end
  end
endmodule

// File: rtl/cfb_host_port.sv
module cfb_host_port #(
  parameter int DW    = 16,
  parameter int AW    = 12,
  parameter int DEPTH = 2480
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_req,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic          fire,
  input  logic [DW-1:0] mem_q,
  output logic          host_ready,
  output logic          wr_en,
  output logic          rd_en,
  output logic          host_rvalid,
  output logic [DW-1:0] host_rdata
);
  logic accept, in_range;
  logic rvalid_q, oob_q;

  assign host_ready = !fire;
  assign accept     = host_req && host_ready;
  assign in_range   = host_addr < AW'(DEPTH);
  assign wr_en      = accept && host_we && in_range;
  assign rd_en      = accept && !host_we && in_range;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      oob_q    <= 1'b0;
    end else begin
      rvalid_q <= accept && !host_we;
      if (accept) oob_q <= !in_range;
    end
  end

  assign host_rvalid = rvalid_q;
  assign host_rdata  = (rvalid_q && !oob_q) ? mem_q : '0;
endmodule

// File: rtl/cfb_ctrl.sv
module cfb_ctrl
  import cfb_pkg::*;
#(
  parameter int DW   = CFB_DW,
  parameter int AW   = CFB_AW,
  parameter int COLS = CFB_COLS,
  parameter int ROWS = CFB_ROWS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_req,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic          host_ready,
  output logic          host_rvalid,
  output logic [DW-1:0] host_rdata,
  input  logic          page_start,
  input  logic          line_start,
  output logic          lb_load,
  output logic [DW-1:0] lb_data,
  output logic          mem_we,
  output logic          mem_oe
);
  localparam int DEPTH = COLS * ROWS;

  logic [1:0]    rst_sync;
  logic          rst_i;
  logic          fire, host_wr, host_rd;
  logic [AW-1:0] rf_addr;
  logic [DW-1:0] mem_q;
  cfb_mem_req_t  req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  cfb_refill #(.AW(AW), .COLS(COLS), .ROWS(ROWS)) u_refill (
    .clk(clk), .rst_n(rst_i), .page_start(page_start), .line_start(line_start),
    .fire(fire), .rd_addr(rf_addr), .load(lb_load)
  );

  cfb_host_port #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) u_host (
    .clk(clk), .rst_n(rst_i), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .fire(fire), .mem_q(mem_q), .host_ready(host_ready),
    .wr_en(host_wr), .rd_en(host_rd), .host_rvalid(host_rvalid), .host_rdata(host_rdata)
  );

  always_comb begin
    req.en    = fire || host_wr || host_rd;
    req.we    = host_wr;
    req.addr  = fire ? rf_addr : host_addr;
    req.wdata = host_wdata;
  end

  cfb_mem #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .en(req.en), .we(req.we), .addr(req.addr), .wdata(req.wdata), .q(mem_q)
  );

  assign lb_data = lb_load ? mem_q : '0;
  assign mem_we  = host_wr;
  assign mem_oe  = host_wr || fire;
endmodule

// File: rtl/cfb_ctrl_chk.sv
module cfb_ctrl_chk #(
  parameter int DW   = 16,
  parameter int AW   = 12,
  parameter int COLS = 80,
  parameter int ROWS = 31
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_req,
  input logic          host_we,
  input logic [AW-1:0] host_addr,
  input logic          host_ready,
  input logic          host_rvalid,
  input logic [DW-1:0] host_rdata,
  input logic          page_start,
  input logic          lb_load,
  input logic          mem_we,
  input logic          mem_oe
);
  localparam int DEPTH = COLS * ROWS;

  p_rvalid_after_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid |-> $past(host_req && host_ready && !host_we));

  p_oob_read_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rvalid && ($past(host_addr) >= AW'(DEPTH))) |-> (host_rdata == '0));

  p_load_blocks_host_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lb_load |-> !$past(host_ready));

  p_page_no_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    page_start |=> !lb_load);

  p_we_accepted_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (host_req && host_we && host_ready && (host_addr < AW'(DEPTH))));

  p_oe_cover_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || !host_ready) |-> mem_oe);

  p_oe_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe |-> (host_ready && !mem_we));
endmodule

bind cfb_ctrl cfb_ctrl_chk #(.DW(DW), .AW(AW), .COLS(COLS), .ROWS(ROWS)) u_chk (.*);

// File: tb/sim_cfb_ctrl.sv
`timescale 1ns/1ps
module sim_cfb_ctrl;
  localparam int NW = 2480;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0, host_we = 1'b0;
  logic [11:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic        host_ready, host_rvalid, lb_load, mem_we, mem_oe;
  logic [15:0] host_rdata, lb_data;
  logic        page_start = 1'b0, line_start = 1'b0;

  int   tests = 0, fails = 0;
  bit   done = 1'b0;
  logic [15:0] shadow [NW];

  always #2.5 clk = ~clk;

  cfb_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
    .host_rvalid(host_rvalid), .host_rdata(host_rdata), .page_start(page_start),
    .line_start(line_start), .lb_load(lb_load), .lb_data(lb_data),
    .mem_we(mem_we), .mem_oe(mem_oe)
  );

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_read(logic [11:0] a);
    return (a < 12'(NW)) ? shadow[a] : 16'h0;
  endfunction

  task automatic host_op(bit we, logic [11:0] a, logic [15:0] d, output int waits);
    bit inr;
    inr = a < 12'(NW);
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d; waits = 0;
    #1;
    while (!host_ready) begin
      @(negedge clk); #1; waits++;
    end
    chk(mem_we == (we && inr), "R8", 32'(mem_we), 32'(we && inr));
    chk(mem_oe == (we && inr), "R8", 32'(mem_oe), 32'(we && inr));
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0;
    if (we) begin
      if (inr) shadow[a] = d;
      chk(!host_rvalid, "R1", 32'(host_rvalid), 0);
    end else begin
      chk(host_rvalid, "R1", 32'(host_rvalid), 1);
      chk(host_rdata == exp_read(a), inr ? "R1" : "R2", 32'(host_rdata), 32'(exp_read(a)));
    end
  endtask

  task automatic pulse_page();
    @(negedge clk); page_start = 1'b1;
    @(negedge clk); page_start = 1'b0;
    chk(!lb_load, "R5", 32'(lb_load), 0);
  endtask

  // exp_row < 0: no transfer expected. reline_at / abort_at: column index or -1.
  task automatic do_line(int exp_row, int reline_at, int abort_at, string tag);
    @(negedge clk); line_start = 1'b1; #1;
    if (exp_row >= 0) chk(!host_ready && mem_oe, "R6", 32'(host_ready), 0);
    else              chk(host_ready && !mem_oe, "R4", 32'(host_ready), 1);
    for (int c = 0; c < 80; c++) begin
      @(negedge clk); line_start = (c == reline_at);
      if (exp_row < 0) chk(!lb_load, "R4", 32'(lb_load), 0);
      else begin
        chk(lb_load, tag, 32'(lb_load), 1);
        chk(lb_data == shadow[exp_row*80 + c], tag, 32'(lb_data), 32'(shadow[exp_row*80 + c]));
      end
      if (c == abort_at) begin
        page_start = 1'b1;
        @(negedge clk); page_start = 1'b0; line_start = 1'b0;
        chk(!lb_load, "R5", 32'(lb_load), 0);
        return;
      end
    end
    @(negedge clk); line_start = 1'b0;
    chk(!lb_load, tag, 32'(lb_load), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int w;
    logic [11:0] a;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!lb_load && !host_rvalid, "R9", 32'(lb_load), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(host_ready, "R9", 32'(host_ready), 1);
    chk(!mem_we && !mem_oe, "R9", 32'(mem_oe), 0);
    chk(!lb_load && !host_rvalid, "R9", 32'(host_rvalid), 0);

    // fill the whole page
    for (int i = 0; i < NW; i++) host_op(1'b1, 12'(i), 16'($urandom), w);

    // directed corners: last word, first out-of-range word, top address
    host_op(1'b0, 12'(NW-1), '0, w);
    host_op(1'b1, 12'(NW), 16'hBEEF, w);     // R2 ignored write
    host_op(1'b0, 12'(NW), '0, w);           // R2 reads zero
    host_op(1'b1, 12'hFFF, 16'h1234, w);
    host_op(1'b0, 12'hFFF, '0, w);
    host_op(1'b0, 12'(NW-1), '0, w);         // R2 neighbour unchanged
    host_op(1'b0, 12'h000, '0, w);

    // constrained random host traffic, a quarter out of range
    for (int i = 0; i < 300; i++) begin
      a = ($urandom_range(0, 3) == 0) ? 12'($urandom_range(NW, 4095))
                                      : 12'($urandom_range(0, NW-1));
      host_op(1'($urandom), a, 16'($urandom), w);
    end

    // full frame, then exhaustion, then restart
    pulse_page();
    for (int r = 0; r < 31; r++) do_line(r, -1, -1, "R3");
    do_line(-1, -1, -1, "R4");
    do_line(-1, -1, -1, "R4");
    pulse_page();
    do_line(0, -1, -1, "R4");

    // extra line pulse during a transfer
    do_line(1, 20, -1, "R7");
    do_line(2, -1, -1, "R7");

    // abort mid-row
    do_line(3, -1, 10, "R5");
    do_line(0, -1, -1, "R5");

    // host write raised together with a line pulse waits the whole row
    fork
      do_line(1, -1, -1, "R6");
      begin
        host_op(1'b1, 12'd95, 16'hA5A5, w);
        chk(w == 80, "R6", 32'(w), 80);
      end
    join
    host_op(1'b0, 12'd95, '0, w);
    chk(w == 0, "R6", 32'(w), 0);

    // random row walk with interleaved host reads
    for (int r = 2; r < 8; r++) begin
      do_line(r, -1, -1, "R3");
      host_op(1'b0, 12'($urandom_range(0, 4095)), '0, w);
    end

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule